// File: doc/BRIEF.md
# Dual-Lane Compare with Condition Merge

This block compares two 64-bit operands as two independent 32-bit lanes. One predicate, chosen by a 3-bit select code, is applied to both lanes at once. The predicates are equality, greater-than and less-than, and the two ordering predicates come in a signed (two's complement) form and an unsigned form. Each lane gives a 1-bit outcome.

The two outcomes are packed into a 4-bit condition field. A later lane-select step can pick either lane's outcome from this field, or use the any-lane or all-lane summary. An operation is presented with a valid strobe, and its result is registered once. The result appears on the clock edge after the valid input, together with an output valid flag.

Top module: `dual_lane_compare`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `res_valid` is 0 and `cond` is 4'b0000.
- R2: `res_valid` is 1 in exactly the cycles that follow a clock edge at which `in_valid` was 1. The matching `cond` value appears in that same cycle.
- R3: `cond[3]` is the predicate outcome for the high lanes (bits 63:32 of both operands). `cond[2]` is the outcome for the low lanes (bits 31:0).
- R4: `cond[1]` is the OR of the two lane outcomes. `cond[0]` is their AND.
- R5: Select code 0 tests whether the lanes are equal.
- R6: Select code 1 tests signed greater-than (A > B) and code 3 tests signed less-than (A < B). Both read each lane as a two's complement number.
- R7: Select code 2 tests unsigned greater-than (A > B) and code 4 tests unsigned less-than (A < B). Both read each lane as a plain binary number.
- R8: Select codes 5, 6 and 7 produce `cond` = 4'b0000.
- R9: When a lane of A equals the same lane of B, codes 1 to 4 give 0 for that lane.
- R10: A cycle with `in_valid` at 0 leaves `cond` unchanged, whatever the operand and select inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the operands and the select code |
| opnd_a | input | 64 | First operand, two 32-bit lanes |
| opnd_b | input | 64 | Second operand, two 32-bit lanes |
| pred_sel | input | 3 | Predicate select code |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| cond | output | 4 | {high, low, OR, AND} condition field |

## Verification
The two lane comparisons run in the same cycle and can disagree. The merge bits are only meaningful when one lane is true and the other is false. The bench provokes this case with mixed-sign lanes, where the signed and unsigned readings give opposite answers, and with operands that are equal in one lane only. Each case is judged against a behavioural model that evaluates the two lanes separately, so a swapped lane or a merge built wrongly from the lane outcomes shows up on the same clock.

// File: rtl/dual_lane_compare.sv
module dual_lane_compare #(
  parameter int LANE_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*LANE_W-1:0] opnd_a,
  input  logic [2*LANE_W-1:0] opnd_b,
  input  logic [SEL_W-1:0]    pred_sel,
  output logic                res_valid,
  output logic [3:0]          cond
);
  localparam int N_LANES = 2;
  localparam logic [SEL_W-1:0] SEL_EQ  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_GTS = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_GTU = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_LTS = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_LTU = SEL_W'(4);

  logic [N_LANES-1:0] hit;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = opnd_a[g*LANE_W +: LANE_W];
    assign lb = opnd_b[g*LANE_W +: LANE_W];
    always_comb begin
      case (pred_sel)
        SEL_EQ:  hit[g] = (la == lb);
        SEL_GTS: hit[g] = ($signed(la) > $signed(lb));
        SEL_GTU: hit[g] = (la > lb);
        SEL_LTS: hit[g] = ($signed(la) < $signed(lb));
        SEL_LTU: hit[g] = (la < lb);
        default: hit[g] = 1'b0;
      endcase
    end
  end

  logic [3:0] merged;
  assign merged = {hit[1], hit[0], |hit, &hit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      cond      <= 4'b0000;
    end else begin
      res_valid <= in_valid;
      if (in_valid) cond <= merged;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);  // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);  // R2
  AST_MERGE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cond[1] == (cond[3] | cond[2])) && (cond[0] == (cond[3] & cond[2])));  // R4
  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred_sel > SEL_LTU) |=> (cond == 4'b0000));  // R8
  AST_EQUAL_NO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opnd_a == opnd_b && pred_sel != SEL_EQ) |=> (cond == 4'b0000));  // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cond));  // R10
endmodule

// File: tb/tb_dual_lane_compare.sv
module tb_dual_lane_compare;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [2:0]  pred_sel = '0;
  logic        res_valid;
  logic [3:0]  cond;

  int n_cmp = 0;
  int n_bad = 0;
  bit run_cmp = 1'b0;
  string cur_tag = "R2";
  string exp_tag = "R2";
  logic  exp_valid = 1'b0;
  logic [3:0] exp_cond = 4'b0000;

  always #5 clk = ~clk;

  dual_lane_compare dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .pred_sel(pred_sel), .res_valid(res_valid), .cond(cond)
  );

  function automatic bit lane_ref(input logic [31:0] x, input logic [31:0] y, input int sel);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint ux = longint'({32'b0, x});
    longint uy = longint'({32'b0, y});
    case (sel)
      0: return ux == uy;
      1: return sx > sy;
      2: return ux > uy;
      3: return sx < sy;
      4: return ux < uy;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] cond_ref(input logic [63:0] a, input logic [63:0] b, input int sel);
    bit h = lane_ref(a[63:32], b[63:32], sel);
    bit l = lane_ref(a[31:0], b[31:0], sel);
    return {h, l, h | l, h & l};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_cond  <= 4'b0000;
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_cond <= cond_ref(opnd_a, opnd_b, int'(pred_sel));
        exp_tag  <= cur_tag;
      end else begin
        exp_tag  <= "R10";
      end
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      n_cmp++;
      if (res_valid !== exp_valid || cond !== exp_cond) begin
        n_bad++;
        $display("FAIL %s: valid=%b cond=%b expected valid=%b cond=%b",
                 exp_tag, res_valid, cond, exp_valid, exp_cond);
      end
    end
  end

  task automatic op(input logic [63:0] a, input logic [63:0] b, input int sel, input string tag);
    @(negedge clk);
    cur_tag  = tag;
    in_valid = 1'b1;
    opnd_a   = a;
    opnd_b   = b;
    pred_sel = 3'(sel);
  endtask

  task automatic idle(input logic [63:0] junk);
    @(negedge clk);
    in_valid = 1'b0;
    opnd_a   = junk;
    opnd_b   = ~junk;
    pred_sel = 3'(junk[2:0]);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (res_valid !== 1'b0 || cond !== 4'b0000) begin
      n_bad++;
      $display("FAIL R1: valid=%b cond=%b expected valid=0 cond=0000", res_valid, cond);
    end
    rst_n = 1'b1;
    run_cmp = 1'b1;
    idle(64'h1234_5678_9abc_def0);
    // R5: equality, one lane equal, the other not
    op(64'h0000_0005_0000_0007, 64'h0000_0005_0000_0008, 0, "R5");
    op(64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444, 0, "R5");
    // R6/R7: mixed sign lanes disagree between signed and unsigned
    op(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 1, "R6");
    op(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 2, "R7");
    op(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 3, "R6");
    op(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 4, "R7");
    op(64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, 1, "R6");
    op(64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, 4, "R7");
    // R3/R4: high true, low false and vice versa
    op(64'h0000_0009_0000_0001, 64'h0000_0003_0000_0002, 2, "R3");
    op(64'h0000_0001_0000_0009, 64'h0000_0003_0000_0002, 2, "R4");
    // R8: unused codes
    op(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 5, "R8");
    op(64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF, 6, "R8");
    op(64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 7, "R8");
    // R9: equal operands give no ordering
    for (int s = 1; s <= 4; s++)
      op(64'h8000_0000_FFFF_FFFF, 64'h8000_0000_FFFF_FFFF, s, "R9");
    // R10: idle cycles with changing junk hold the result
    op(64'h0000_0002_0000_0002, 64'h0000_0001_0000_0001, 1, "R10");
    idle(64'hDEAD_BEEF_0BAD_F00D);
    idle(64'h0123_4567_89AB_CDEF);
    idle(64'hFFFF_FFFF_FFFF_FFFF);
    // R2: mixed back-to-back and gapped traffic
    begin
      logic [63:0] x = 64'h9E37_79B9_7F4A_7C15;
      logic [63:0] y = 64'hC2B2_AE3D_27D4_EB4F;
      for (int i = 0; i < 300; i++) begin
        x = {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
        y = y * 64'd6364136223846793005 + 64'd1442695040888963407;
        if (i % 7 == 3) idle(x ^ y);
        else if (i % 5 == 0) op(x, {x[63:32], y[31:0]}, i % 8, "R2");
        else op(x, y, i % 8, "R2");
      end
    end
    idle(64'h0);
    idle(64'h0);
    run_cmp = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule